// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a mode-0 SPI link for a 512-byte serial memory. It runs on the system clock. Chip select, serial clock and serial input are synchronised into that clock, and the serial clock edges are detected there. A transaction starts with an 8-bit instruction. The block decodes it and then either collects an address and data bytes, streams bytes out of the memory array, or streams the composed status byte.

Commands that change state are not carried out here. The latch set and clear commands, the status write and every array data byte are each handed to a separate write controller as a one-cycle request. The write controller returns the latch, protection and watchdog fields and a busy flag, and the front end uses these to build the status byte. The serial output comes with an enable line, so the pad can be tri-stated.

Top module: `spi_mem_front`

## Requirements
- R1: SI is captured on rising SCK edges, and every byte travels MSB first. Shifting in 0x3C as a status-write data byte gives a request carrying 0x3C.
- R2: Opcode 0x06 gives one request of kind 0, and opcode 0x04 gives one request of kind 1. Both take no further bytes, and extra bytes in the same selection produce nothing.
- R3: Opcode 0x05 streams the status byte {2'b00, wd[1], wd[0], bl[1], bl[0], wel, 1'b0} MSB first. The first bit appears after the falling edge that follows the eighth rising edge, and the byte repeats for as long as clocking continues.
- R4: While wr_busy is high, the status byte reads 0xFF: the busy flag in bit 0 and every other bit forced to 1.
- R5: Opcode 0000_A011 (bit 3 = address bit 8) followed by one address byte streams array bytes MSB first, starting at {A, address byte}. The array address appears on mem_raddr.
- R6: During a read the address advances by one after each byte and wraps from 0x1FF to 0x000.
- R7: Opcode 0000_A010 followed by an address byte turns each later data byte into a request of kind 3 with its address and data. The address advances within a 4-byte page: the low 2 bits wrap and the upper bits stay fixed.
- R8: Opcode 0x01 turns the next byte into one request of kind 2 carrying that byte. Later bytes in the same selection are ignored.
- R9: An undefined opcode produces no request and leaves SO disabled until CS rises. The next selection is decoded normally.
- R10: spi_so_oe is low whenever CS is high, and high only while a status or array byte is being shifted out.
- R11: After reset, spi_so_oe and wr_req are low. No command is taken until CS has made a high-to-low transition, so a selection already active at reset is ignored.
- R12: CS rising part-way through a byte discards the partial bits, and the next selection starts again at the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO pad |
| mem_raddr | output | 9 | Array read address |
| mem_rdata | input | 8 | Array read data, combinational from mem_raddr |
| stat_wel | input | 1 | Write-enable latch from write controller |
| stat_bl | input | 2 | Block protect field |
| stat_wd | input | 2 | Watchdog period field |
| wr_busy | input | 1 | Internal write in progress |
| wr_req | output | 1 | One-cycle request strobe |
| wr_kind | output | 2 | 0 set latch, 1 clear latch, 2 status write, 3 array byte |
| wr_addr | output | 9 | Array byte address for kind 3 |
| wr_data | output | 8 | Data byte for kinds 2 and 3 |

## Verification
Each pin passes through two synchroniser stages and one edge register, so a request or an SO change registers on the third system clock edge after the SCK edge that causes it. The bench holds each SCK phase for eight system clocks. It samples SO at the end of the low phase, just before the rising edge, which leaves five spare cycles. Requests are captured by a monitor at the falling clock edge and checked only after CS has been high for several phases, so no check lands on a cycle where the result is still moving.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    K_SET_WEL = 2'd0,
    K_CLR_WEL = 2'd1,
    K_WR_STAT = 2'd2,
    K_WR_BYTE = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    OP_SETL, OP_CLRL, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    S_OPC, S_ADR, S_WDAT, S_SDAT, S_RDO, S_SRO, S_SKIP
  } seq_st_e;

  // Opcode classification; bit 3 of array opcodes is address bit 8.
  function automatic op_e decode_op(input logic [BYTE_W-1:0] b);
    if (b == 8'h06) return OP_SETL;
    if (b == 8'h04) return OP_CLRL;
    if (b == 8'h05) return OP_RDSR;
    if (b == 8'h01) return OP_WRSR;
    if (b[7:4] == 4'h0 && b[2:0] == 3'b011) return OP_READ;
    if (b[7:4] == 4'h0 && b[2:0] == 3'b010) return OP_WRITE;
    return OP_BAD;
  endfunction

  // Busy forces every bit high; otherwise fields sit at their fixed positions.
  function automatic logic [BYTE_W-1:0] status_pack(input logic busy, input logic wel,
                                                    input logic [1:0] bl, input logic [1:0] wd);
    if (busy) return '1;
    return {2'b00, wd, bl, wel, 1'b0};
  endfunction

  // Advance within an aligned page of 2**pw bytes.
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a, input int pw);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pw) - 1);
    return (a & ~m) | ((a + {{(ADDR_W-1){1'b0}}, 1'b1}) & m);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_hi,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  localparam int NPIN = 3;
  logic [NPIN-1:0] stg [STAGES];
  logic cs_q, sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      stg[0] <= {cs_n, sck, si};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      cs_q  <= stg[STAGES-1][2];
      sck_q <= stg[STAGES-1][1];
    end
  end

  assign cs_hi    = stg[STAGES-1][2];
  assign si_s     = stg[STAGES-1][0];
  assign cs_fall  = cs_q & ~stg[STAGES-1][2];
  assign sck_rise = ~sck_q & stg[STAGES-1][1];
  assign sck_fall = sck_q & ~stg[STAGES-1][1];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_mem_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              si_s,
  output logic [ADDR_W-1:0] addr,
  output logic              out_stat,
  output logic              out_mem,
  output logic              first_bit,
  output logic              wr_req,
  output req_kind_e         wr_kind,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              armed
);
  seq_st_e          st;
  logic [2:0]       cnt;
  logic [6:0]       sh;
  logic             hi_bit, rd_mode;
  logic [BYTE_W-1:0] byte_in;
  logic             byte_done;

  assign byte_in   = {sh, si_s};
  assign byte_done = sck_rise && armed && !cs_hi && cnt == 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OPC; cnt <= '0; sh <= '0; hi_bit <= 1'b0; rd_mode <= 1'b0;
      addr <= '0; armed <= 1'b0; wr_req <= 1'b0; wr_kind <= K_SET_WEL;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      armed  <= armed | cs_fall;
      if (cs_hi || cs_fall) begin
        st  <= S_OPC;
        cnt <= '0;
      end else if (sck_rise && armed) begin
        cnt <= cnt + 3'd1;
        sh  <= byte_in[6:0];
        if (cnt == 3'd7) begin
          case (st)
            S_OPC: begin
              case (decode_op(byte_in))
                OP_SETL:  begin wr_req <= 1'b1; wr_kind <= K_SET_WEL; st <= S_SKIP; end
                OP_CLRL:  begin wr_req <= 1'b1; wr_kind <= K_CLR_WEL; st <= S_SKIP; end
                OP_RDSR:  st <= S_SRO;
                OP_WRSR:  st <= S_SDAT;
                OP_READ:  begin hi_bit <= byte_in[3]; rd_mode <= 1'b1; st <= S_ADR; end
                OP_WRITE: begin hi_bit <= byte_in[3]; rd_mode <= 1'b0; st <= S_ADR; end
                default:  st <= S_SKIP;
              endcase
            end
            S_ADR: begin
              addr <= {hi_bit, byte_in};
              st   <= rd_mode ? S_RDO : S_WDAT;
            end
            S_WDAT: begin
              wr_req <= 1'b1; wr_kind <= K_WR_BYTE;
              wr_addr <= addr; wr_data <= byte_in;
              addr <= page_next(addr, PAGE_W);
            end
            S_SDAT: begin
              wr_req <= 1'b1; wr_kind <= K_WR_STAT; wr_data <= byte_in;
              st <= S_SKIP;
            end
            S_RDO: addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
            default: ;
          endcase
        end
      end
    end
  end

  assign out_stat  = (st == S_SRO);
  assign out_mem   = (st == S_RDO);
  assign first_bit = (cnt == 3'd0);

  p_rd_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDO && byte_done && addr == '1) |=> addr == '0);
  p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && byte_done && addr[PAGE_W-1:0] == '1)
      |=> (addr[PAGE_W-1:0] == '0 && $stable(addr[ADDR_W-1:PAGE_W])));
  p_arm_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_req);
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
endmodule

// File: rtl/spi_so_shift.sv
module spi_so_shift
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sck_fall,
  input  logic              out_stat,
  input  logic              out_mem,
  input  logic              first_bit,
  input  logic [BYTE_W-1:0] stat_byte,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic              so,
  output logic              so_oe
);
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] nxt;

  assign nxt = out_stat ? stat_byte : mem_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so <= 1'b0; so_oe <= 1'b0; sh <= '0;
    end else if (cs_hi) begin
      so <= 1'b0; so_oe <= 1'b0;
    end else if (sck_fall && (out_stat || out_mem)) begin
      so_oe <= 1'b1;
      if (first_bit) begin
        so <= nxt[BYTE_W-1];
        sh <= {nxt[BYTE_W-2:0], 1'b0};
      end else begin
        so <= sh[BYTE_W-1];
        sh <= {sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  p_so_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !so_oe);
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sck,
  input  logic        spi_si,
  output logic        spi_so,
  output logic        spi_so_oe,
  output logic [8:0]  mem_raddr,
  input  logic [7:0]  mem_rdata,
  input  logic        stat_wel,
  input  logic [1:0]  stat_bl,
  input  logic [1:0]  stat_wd,
  input  logic        wr_busy,
  output logic        wr_req,
  output logic [1:0]  wr_kind,
  output logic [8:0]  wr_addr,
  output logic [7:0]  wr_data
);
  logic cs_hi, cs_fall, sck_rise, sck_fall, si_s;
  logic out_stat, out_mem, first_bit, armed;
  logic [ADDR_W-1:0] addr;
  req_kind_e kind;
  logic [BYTE_W-1:0] stat_byte;
  logic ld_stat;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
    .cs_hi(cs_hi), .cs_fall(cs_fall), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  spi_cmd_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_fall(cs_fall), .sck_rise(sck_rise),
    .si_s(si_s), .addr(addr), .out_stat(out_stat), .out_mem(out_mem),
    .first_bit(first_bit), .wr_req(wr_req), .wr_kind(kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .armed(armed)
  );

  assign stat_byte = status_pack(wr_busy, stat_wel, stat_bl, stat_wd);

  spi_so_shift u_out (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_fall(sck_fall), .out_stat(out_stat),
    .out_mem(out_mem), .first_bit(first_bit), .stat_byte(stat_byte), .mem_byte(mem_rdata),
    .so(spi_so), .so_oe(spi_so_oe)
  );

  assign mem_raddr = addr;
  assign wr_kind   = kind;

  // Status load event, brought out for the busy check.
  assign ld_stat = sck_fall & out_stat & first_bit & ~cs_hi & armed;

  p_busy_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stat && wr_busy) |=> spi_so);
  p_oe_only_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_stat && !out_mem && cs_hi) |=> !spi_so_oe);
endmodule

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  // {busy, wel, bl[1:0], wd[1:0], expected status}
  localparam logic [13:0] SR_VEC [6] = '{
    {1'b0, 1'b1, 2'b00, 2'b00, 8'h02},
    {1'b0, 1'b0, 2'b11, 2'b00, 8'h0C},
    {1'b0, 1'b0, 2'b01, 2'b10, 8'h24},
    {1'b0, 1'b1, 2'b10, 2'b11, 8'h3A},
    {1'b1, 1'b0, 2'b00, 2'b00, 8'hFF},
    {1'b1, 1'b1, 2'b11, 2'b01, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  logic so, so_oe, wr_req;
  logic [8:0] mem_raddr, wr_addr;
  logic [7:0] mem_rdata, wr_data;
  logic [1:0] wr_kind;
  logic wel = 1'b0, busy = 1'b0;
  logic [1:0] bl = 2'b00, wd = 2'b00;
  int total = 0, fails = 0, req_cnt = 0, oe_cnt = 0;
  logic [1:0] rk [32];
  logic [8:0] ra [32];
  logic [7:0] rd [32];
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_pat(input logic [8:0] a);
    return a[7:0] ^ (a[8] ? 8'hA5 : 8'h3C);
  endfunction
  assign mem_rdata = mem_pat(mem_raddr);

  spi_mem_front u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .stat_wel(wel), .stat_bl(bl), .stat_wd(wd), .wr_busy(busy),
    .wr_req(wr_req), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (so_oe) oe_cnt++;
    if (wr_req && req_cnt < 32) begin
      rk[req_cnt] = wr_kind; ra[req_cnt] = wr_addr; rd[req_cnt] = wr_data;
      req_cnt++;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
  endtask
  task automatic desel();
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
  endtask
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    rx = '0; oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so; oe_all &= so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, rx2;
    logic oe;
    int base, oe0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_req && !so_oe, "R11 reset state", {so_oe, wr_req}, 0);
    // R11: selection active through reset is ignored
    xfer(8'h06, rx, oe);
    desel();
    chk(req_cnt == 0, "R11 no command before CS falls", req_cnt, 0);

    // R2 latch set / clear
    sel(); xfer(8'h06, rx, oe); xfer(8'h04, rx, oe); desel();
    chk(req_cnt == 1 && rk[0] == 2'd0, "R2 set-latch single request", req_cnt, 1);
    sel(); xfer(8'h04, rx, oe); desel();
    chk(req_cnt == 2 && rk[1] == 2'd1, "R2 clear-latch kind", rk[1], 1);

    // R3/R4 status table
    foreach (SR_VEC[k]) begin
      {busy, wel, bl, wd} = SR_VEC[k][13:8];
      sel(); xfer(8'h05, rx, oe); xfer(8'h00, rx, oe);
      xfer(8'h00, rx2, oe); desel();
      chk(rx == SR_VEC[k][7:0], SR_VEC[k][13] ? "R4 busy status" : "R3 status byte", rx, SR_VEC[k][7:0]);
      chk(rx2 == SR_VEC[k][7:0], "R3 status repeats", rx2, SR_VEC[k][7:0]);
      chk(oe, "R10 SO enabled during status", oe, 1);
    end
    busy = 1'b0;
    chk(!so_oe, "R10 SO disabled after CS high", so_oe, 0);

    // R5 read with address bit 8 from opcode
    sel(); xfer(8'h0B, rx, oe); xfer(8'h23, rx, oe);
    xfer(8'h00, rx, oe); xfer(8'h00, rx2, oe); desel();
    chk(rx == mem_pat(9'h123), "R5 read first byte", rx, mem_pat(9'h123));
    chk(rx2 == mem_pat(9'h124), "R5 read next byte", rx2, mem_pat(9'h124));

    // R6 wrap at top of array
    sel(); xfer(8'h0B, rx, oe); xfer(8'hFF, rx, oe);
    xfer(8'h00, rx, oe); xfer(8'h00, rx2, oe); desel();
    chk(rx == mem_pat(9'h1FF), "R6 read last address", rx, mem_pat(9'h1FF));
    chk(rx2 == mem_pat(9'h000), "R6 wrap to zero", rx2, mem_pat(9'h000));

    // R7 array write with page wrap
    base = req_cnt;
    sel(); xfer(8'h02, rx, oe); xfer(8'hFE, rx, oe);
    xfer(8'h11, rx, oe); xfer(8'h22, rx, oe); xfer(8'h33, rx, oe); desel();
    chk(req_cnt == base + 3, "R7 one request per byte", req_cnt - base, 3);
    chk(rk[base] == 2'd3 && ra[base] == 9'h0FE && rd[base] == 8'h11, "R7 first byte", ra[base], 9'h0FE);
    chk(ra[base+1] == 9'h0FF && rd[base+1] == 8'h22, "R7 second byte", ra[base+1], 9'h0FF);
    chk(ra[base+2] == 9'h0FC && rd[base+2] == 8'h33, "R7 page wrap", ra[base+2], 9'h0FC);

    // R8 / R1 status write, MSB first, extra byte ignored
    base = req_cnt;
    sel(); xfer(8'h01, rx, oe); xfer(8'h3C, rx, oe); xfer(8'h55, rx, oe); desel();
    chk(req_cnt == base + 1 && rk[base] == 2'd2, "R8 one status-write request", req_cnt - base, 1);
    chk(rd[base] == 8'h3C, "R1 MSB-first data", rd[base], 8'h3C);

    // R9 unknown opcode
    base = req_cnt; oe0 = oe_cnt;
    sel(); xfer(8'hFF, rx, oe); xfer(8'h06, rx, oe); xfer(8'h05, rx, oe); desel();
    chk(req_cnt == base, "R9 no request after bad opcode", req_cnt - base, 0);
    chk(oe_cnt == oe0, "R9 SO stays disabled", oe_cnt - oe0, 0);
    sel(); xfer(8'h06, rx, oe); desel();
    chk(req_cnt == base + 1 && rk[base] == 2'd0, "R9 next selection decodes", req_cnt - base, 1);

    // R12 partial byte discarded
    base = req_cnt;
    sel();
    for (int i = 0; i < 4; i++) begin
      si = 1'b0; repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    desel();
    sel(); xfer(8'h04, rx, oe); desel();
    chk(req_cnt == base + 1 && rk[base] == 2'd1, "R12 resync at opcode", rk[base], 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule